// File: doc/BRIEF.md
# I2C Target Register Port with Bus Timeout

This block is a serial-bus target. It gives an external bus master access to a small file of sixteen byte-wide registers. The SCL and SDA inputs arrive already synchronised to the system clock. The block finds START, STOP and repeated-START conditions on them and checks the 7-bit target address. One bit of that address comes from a strap pin, so two targets can share one bus. It acknowledges bytes and moves data in both directions through an auto-incrementing register pointer. Locations 0Ah to 0Fh return a fixed 48-bit identity value and cannot be written.

A write transfer carries the register pointer first and then data bytes. A read transfer returns data starting at the pointer. A master that sets the pointer and then sends a repeated START gets a random-access read.

The block also has a watchdog, which counts ticks of a slow timebase while SCL is low. If SCL stays low for the configured number of ticks, the block lets go of SDA and returns to idle, ready for a fresh START. The watchdog advances only on ticks, so it stays dormant while the timebase is stopped. The output `sda_oe` means "pull SDA low". The pad driver lies outside this block.

Top module: `i2cr_target`

## Requirements
- R1: After reset, `sda_oe` is 0, the register pointer is 0 and registers 00h–09h read as 00h.
- R2: The block acknowledges an address byte only when its upper 7 bits equal ADDR_BASE with bit PIN_BIT replaced by `addr_pin`. On any other address, SDA stays released for the rest of the transfer.
- R3: In a write, every byte is acknowledged and bits arrive MSB first. The first byte after the address loads the pointer from its low 4 bits. Each later byte is stored at the pointer, and the pointer then increments.
- R4: In a read (address LSB = 1), bytes are sent MSB first starting at the pointer. The pointer increments after each byte and wraps from 0Fh to 00h.
- R5: An acknowledge pulls SDA low from the SCL fall that follows the eighth bit. It releases SDA at the next SCL fall. SDA is never newly pulled low while SCL is high.
- R6: A NACK from the master after a read byte ends the transmission. SDA then stays released, even under further clocks, until the next START.
- R7: A repeated START with no STOP before it restarts address matching. The pointer keeps the value it had.
- R8: When SCL stays low for TIMEOUT_TICKS `osc_tick` pulses, SDA is released within one cycle and the protocol returns to idle. A following START is accepted normally.
- R9: Without `osc_tick` pulses, SCL held low for any length of time never triggers the timeout.
- R10: Location 0Ah+k reads ID_VALUE[8k+7:8k] for k = 0..5. Writes to 0Ah–0Fh are acknowledged but change nothing, and the pointer still increments.
- R11: A STOP returns the block to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level |
| addr_pin | input | 1 | Strap level for the pin-selected address bit |
| osc_tick | input | 1 | One-cycle pulse per timebase tick; drives the timeout |
| sda_oe | output | 1 | 1 = pull SDA low |

## Verification
A wrong internal state shows at the ports within one bus bit, as SDA pulled low or left released at the wrong point. An address or acknowledge fault appears on the ninth clock of the byte where it occurs. A pointer fault appears only in the data of the next read, so each write in the bench is followed by a random-access read-back. Wrap-around and the read-only ID locations are also read back. A timeout fault shows as `sda_oe` still set one cycle after the final tick, or as a START that is ignored afterwards.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WR,
        ST_WACK,
        ST_RD,
        ST_MACK
    } i2cr_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } i2cr_bus_ev_t;

    localparam int ADDR_W = 7;

    // Expected target address: base with the strapped bit forced to the pin level
    function automatic logic addr_hit(input logic [ADDR_W-1:0] rx,
                                      input logic [ADDR_W-1:0] base,
                                      input int unsigned pin_bit,
                                      input logic pin);
        logic [ADDR_W-1:0] want;
        want = base;
        want[pin_bit] = pin;
        return rx == want;
    endfunction

endpackage

// File: rtl/i2cr_bus_events.sv
module i2cr_bus_events
    import i2cr_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         scl_i,
    input  logic         sda_i,
    output i2cr_bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev.start = scl_q & scl_i & sda_q & ~sda_i;
        ev.stop  = scl_q & scl_i & ~sda_q & sda_i;
        ev.rise  = ~scl_q & scl_i;
        ev.fall  = scl_q & ~scl_i;
    end
endmodule

// File: rtl/i2cr_scl_watchdog.sv
module i2cr_scl_watchdog #(
    parameter int unsigned LIMIT = 819
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic tick,
    output logic fire
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || scl_i)
            low_cnt <= '0;
        else if (tick && low_cnt < TW'(LIMIT))
            low_cnt <= low_cnt + 1'b1;
    end

    assign fire = tick & ~scl_i & (low_cnt == TW'(LIMIT - 1));

    // R9
    cnt_bounded_chk: assert property (@(posedge clk) disable iff (rst)
        low_cnt <= TW'(LIMIT));

    // R9
    cnt_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> low_cnt == 0 || $stable(low_cnt));
endmodule

// File: rtl/i2cr_regs.sv
module i2cr_regs #(
    parameter int NUM_REGS = 16,
    parameter int ID_FIRST = 10,
    parameter int PTR_W    = $clog2(NUM_REGS),
    parameter logic [8*(NUM_REGS-ID_FIRST)-1:0] ID_VALUE = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [7:0]       rdata
);
    logic [7:0] store [ID_FIRST];
    int id_k;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ID_FIRST; i++) store[i] <= 8'h00;
        end else if (we && waddr < PTR_W'(ID_FIRST)) begin
            store[waddr] <= wdata;
        end
    end

    always_comb begin
        id_k  = int'(raddr) - ID_FIRST;
        rdata = 8'h00;
        if (raddr < PTR_W'(ID_FIRST))
            rdata = store[raddr];
        else
            rdata = ID_VALUE[8*id_k +: 8];
    end

    // R3
    wr_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (we && waddr < PTR_W'(ID_FIRST)) |=> store[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/i2cr_target.sv
module i2cr_target
    import i2cr_pkg::*;
#(
    parameter int unsigned        TIMEOUT_TICKS = 819,
    parameter logic [ADDR_W-1:0]  ADDR_BASE     = 7'h68,
    parameter int unsigned        PIN_BIT       = 0,
    parameter int                 NUM_REGS      = 16,
    parameter int                 ID_FIRST      = 10,
    parameter logic [8*(NUM_REGS-ID_FIRST)-1:0] ID_VALUE = 48'hA1B2C3D4E5F6
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic addr_pin,
    input  logic osc_tick,
    output logic sda_oe
);
    localparam int PTR_W = $clog2(NUM_REGS);

    i2cr_state_e      st;
    i2cr_bus_ev_t     ev;
    logic [2:0]       bitcnt;
    logic [7:0]       shreg;
    logic [7:0]       txsr;
    logic [PTR_W-1:0] ptr;
    logic             got, rw, ptr_phase, nack, tmo;
    logic             we;
    logic [7:0]       rdata;

    i2cr_bus_events u_ev (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    i2cr_scl_watchdog #(.LIMIT(TIMEOUT_TICKS)) u_wd (
        .clk(clk), .rst(rst), .scl_i(scl_i), .tick(osc_tick), .fire(tmo)
    );

    assign we = (st == ST_WR) && ev.fall && got && !ptr_phase;

    i2cr_regs #(
        .NUM_REGS(NUM_REGS), .ID_FIRST(ID_FIRST), .PTR_W(PTR_W), .ID_VALUE(ID_VALUE)
    ) u_regs (
        .clk(clk), .rst(rst), .we(we), .waddr(ptr), .wdata(shreg),
        .raddr(ptr), .rdata(rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            txsr      <= '0;
            ptr       <= '0;
            got       <= 1'b0;
            rw        <= 1'b0;
            ptr_phase <= 1'b0;
            nack      <= 1'b0;
            sda_oe    <= 1'b0;
        end else if (tmo || ev.stop) begin
            st     <= ST_IDLE;
            got    <= 1'b0;
            sda_oe <= 1'b0;
        end else if (ev.start) begin
            st     <= ST_ADDR;
            bitcnt <= '0;
            got    <= 1'b0;
            sda_oe <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (ev.rise) begin
                        shreg  <= {shreg[6:0], sda_i};
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == 3'd7) got <= 1'b1;
                    end else if (ev.fall && got) begin
                        got <= 1'b0;
                        if (addr_hit(shreg[7:1], ADDR_BASE, PIN_BIT, addr_pin)) begin
                            sda_oe <= 1'b1;
                            rw     <= shreg[0];
                            st     <= ST_AACK;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                ST_AACK: begin
                    if (ev.fall) begin
                        bitcnt <= '0;
                        if (rw) begin
                            txsr   <= rdata;
                            sda_oe <= ~rdata[7];
                            st     <= ST_RD;
                        end else begin
                            sda_oe    <= 1'b0;
                            ptr_phase <= 1'b1;
                            st        <= ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (ev.rise) begin
                        shreg  <= {shreg[6:0], sda_i};
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == 3'd7) got <= 1'b1;
                    end else if (ev.fall && got) begin
                        got    <= 1'b0;
                        sda_oe <= 1'b1;
                        st     <= ST_WACK;
                        if (ptr_phase) begin
                            ptr       <= shreg[PTR_W-1:0];
                            ptr_phase <= 1'b0;
                        end else begin
                            ptr <= ptr + 1'b1;
                        end
                    end
                end
                ST_WACK: begin
                    if (ev.fall) begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        st     <= ST_WR;
                    end
                end
                ST_RD: begin
                    if (ev.rise) begin
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == 3'd7) got <= 1'b1;
                    end else if (ev.fall) begin
                        if (got) begin
                            got    <= 1'b0;
                            sda_oe <= 1'b0;
                            ptr    <= ptr + 1'b1;
                            st     <= ST_MACK;
                        end else begin
                            txsr   <= {txsr[6:0], 1'b0};
                            sda_oe <= ~txsr[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.rise) begin
                        nack <= sda_i;
                    end else if (ev.fall) begin
                        if (nack) begin
                            st <= ST_IDLE;
                        end else begin
                            txsr   <= rdata;
                            sda_oe <= ~rdata[7];
                            bitcnt <= '0;
                            st     <= ST_RD;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R5
    ack_starts_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_i);

    // R11
    idle_released_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_oe);

    // R2
    addr_phase_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ADDR) |-> !sda_oe);

    // R8
    tmo_release_chk: assert property (@(posedge clk) disable iff (rst)
        tmo |=> (!sda_oe && st == ST_IDLE));
endmodule

// File: tb/tb_i2cr_target.sv
module tb_i2cr_target;
    localparam int HP = 4;
    localparam int TMO = 6;
    localparam logic [6:0] DEV = 7'h69;   // base 68h with bit0 strapped to 1
    // {pointer, write data, expected read-back}
    localparam logic [19:0] VEC [8] = '{
        {4'h0, 8'h11, 8'h11}, {4'h3, 8'h5A, 8'h5A}, {4'h9, 8'hC3, 8'hC3},
        {4'hA, 8'h00, 8'hF6}, {4'hF, 8'h77, 8'hA1}, {4'h5, 8'hFF, 8'hFF},
        {4'h1, 8'h80, 8'h80}, {4'hC, 8'h12, 8'hD4}
    };

    logic clk = 0, rst = 1, scl = 1, sda_m = 1, osc_tick = 0;
    logic addr_pin = 1'b1;
    logic sda_oe, sda_bus;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    i2cr_target #(.TIMEOUT_TICKS(TMO)) dut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus),
        .addr_pin(addr_pin), .osc_tick(osc_tick), .sda_oe(sda_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hp(); repeat (HP) @(negedge clk); endtask
    task automatic bus_start(); sda_m = 1; hp(); scl = 1; hp(); sda_m = 0; hp(); scl = 0; hp(); endtask
    task automatic bus_stop(); sda_m = 0; hp(); scl = 1; hp(); sda_m = 1; hp(); endtask
    task automatic wbit(input logic b); sda_m = b; hp(); scl = 1; hp(); scl = 0; hp(); endtask
    task automatic rbit(output logic b); sda_m = 1; hp(); scl = 1; hp(); b = sda_bus; scl = 0; hp(); endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(a);
        ack = ~a;
    endtask

    task automatic rbyte(output logic [7:0] d, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
        wbit(~mack);
    endtask

    task automatic tick(); @(negedge clk) osc_tick = 1; @(negedge clk) osc_tick = 0; endtask

    // write pointer then repeated START into read
    task automatic seek_read(input logic [3:0] p, input string req);
        logic a;
        bus_start(); wbyte({DEV, 1'b0}, a); wbyte({4'h0, p}, a);
        bus_start(); wbyte({DEV, 1'b1}, a);
        chk(req, {7'd0, a}, 8'h01);
    endtask

    initial begin
        logic a;
        logic [7:0] d;
        repeat (5) @(negedge clk);
        chk("R1 sda released in reset", {7'd0, sda_oe}, 8'h00);
        rst = 0;
        hp();
        chk("R1 sda released after reset", {7'd0, sda_oe}, 8'h00);
        // R1 reset value, read with pointer at 0 (no seek)
        bus_start(); wbyte({DEV, 1'b1}, a); rbyte(d, 1'b0); bus_stop();
        chk("R1 reg00 reset value", d, 8'h00);
        seek_read(4'h4, "R7 ack after repeated start");
        rbyte(d, 1'b0); bus_stop();
        chk("R1 reg04 reset value", d, 8'h00);

        // table walk: R3 write, R7 random read, R4/R10 data
        foreach (VEC[i]) begin
            bus_start();
            wbyte({DEV, 1'b0}, a); chk("R2 addr ack", {7'd0, a}, 8'h01);
            wbyte({4'h0, VEC[i][19:16]}, a); chk("R3 pointer ack", {7'd0, a}, 8'h01);
            wbyte(VEC[i][15:8], a); chk("R3 data ack", {7'd0, a}, 8'h01);
            chk("R5 ack released", {7'd0, sda_oe}, 8'h00);
            bus_stop();
            seek_read(VEC[i][19:16], "R7 read addr ack");
            rbyte(d, 1'b0); bus_stop();
            chk("R4 R10 read back", d, VEC[i][7:0]);
        end

        // R2 wrong strap value: no ack, byte ignored
        bus_start(); wbyte({7'h68, 1'b0}, a);
        chk("R2 mismatch no ack", {7'd0, a}, 8'h00);
        rbyte(d, 1'b0);
        chk("R2 mismatch sda released", d, 8'hFF);
        bus_stop();

        // R3 burst write with auto-increment
        bus_start(); wbyte({DEV, 1'b0}, a); wbyte(8'h02, a);
        wbyte(8'h21, a); wbyte(8'h22, a); wbyte(8'h23, a); bus_stop();
        seek_read(4'h2, "R7 ack");
        rbyte(d, 1'b1); chk("R3 burst reg02", d, 8'h21);
        rbyte(d, 1'b1); chk("R3 burst reg03", d, 8'h22);
        rbyte(d, 1'b0); chk("R3 burst reg04", d, 8'h23);
        bus_stop();

        // R10 write into ID ignored, pointer still advances
        bus_start(); wbyte({DEV, 1'b0}, a); wbyte(8'h09, a);
        wbyte(8'h31, a); wbyte(8'h32, a);
        chk("R10 id write acked", {7'd0, a}, 8'h01);
        wbyte(8'h33, a); bus_stop();
        seek_read(4'h9, "R7 ack");
        rbyte(d, 1'b1); chk("R3 reg09 written", d, 8'h31);
        rbyte(d, 1'b1); chk("R10 reg0A unchanged", d, 8'hF6);
        rbyte(d, 1'b0); chk("R10 reg0B unchanged", d, 8'hE5);
        bus_stop();

        // R4 wrap from 0F to 00
        seek_read(4'hF, "R7 ack");
        rbyte(d, 1'b1); chk("R4 reg0F", d, 8'hA1);
        rbyte(d, 1'b1); chk("R4 wrap reg00", d, 8'h11);
        rbyte(d, 1'b0); chk("R4 wrap reg01", d, 8'h80);
        bus_stop();

        // R6 NACK ends transmission
        seek_read(4'h2, "R7 ack");
        rbyte(d, 1'b0); chk("R6 byte before nack", d, 8'h21);
        rbyte(d, 1'b0); chk("R6 released after nack", d, 8'hFF);
        bus_stop();
        bus_start(); wbyte({DEV, 1'b1}, a); rbyte(d, 1'b0); bus_stop();
        chk("R4 pointer advanced past nacked byte", d, 8'h22);

        // R8/R9 timeout while driving a 0 data bit
        seek_read(4'h2, "R7 ack");
        chk("R4 first bit driven", {7'd0, sda_oe}, 8'h01);
        for (int k = 0; k < TMO - 1; k++) tick();
        hp();
        chk("R8 held before limit", {7'd0, sda_oe}, 8'h01);
        repeat (60) @(negedge clk);
        chk("R9 no ticks no timeout", {7'd0, sda_oe}, 8'h01);
        tick();
        @(negedge clk);
        chk("R8 released after timeout", {7'd0, sda_oe}, 8'h00);
        bus_start(); wbyte({DEV, 1'b1}, a);
        chk("R8 start accepted after timeout", {7'd0, a}, 8'h01);
        rbyte(d, 1'b0); bus_stop();
        chk("R8 pointer kept", d, 8'h21);
        chk("R11 idle after stop", {7'd0, sda_oe}, 8'h00);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule